// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the management-side master of a two-wire PHY management bus. It derives the management clock (MDC) from the system clock with a programmable divider and shifts one complete management frame per host request onto the data line. The data line is split into output, output-enable and input pins, so the master can release the line. A pad-level tri-state buffer and an external pull-up complete the connection.

A host starts a transaction with a one-cycle `cmd_start` pulse. The pulse carries the frame flavour (direct register frame or extended indirect frame), a 2-bit opcode, a 5-bit port address, a 5-bit register/device address and 16 bits of write data. While the frame runs, `busy` is held high. When the frame completes, `done` pulses for one cycle. After a read, the captured 16-bit word is presented on `rd_data`. An extended register access takes two transactions from the host: an address frame, then a data frame.

Top module: `mdio_master`

## Requirements
- R1: During and right after reset, `mdc`, `mdio_oe`, `busy` and `done` are low and `rd_data` is zero.
- R2: While a frame runs, each MDC half period lasts `mdc_half_div`+1 system cycles, so a full MDC period is 2·(`mdc_half_div`+1) cycles. MDC stays low while idle.
- R3: Every frame opens with 32 MDC cycles in which the master drives '1'.
- R4: With `cmd_ext`=0 the 14 bits after the preamble are start '01', then `cmd_op`, `cmd_phy` and `cmd_reg`, each MSB first. Opcode '10' is a read. Every other opcode is driven as a write: turnaround '10' followed by `cmd_wdata`, MSB first.
- R5: With `cmd_ext`=1 the start field is '00'. Opcodes '00' (set address) and '01' (write) are driven like a write, with turnaround '10' and the 16-bit word. Opcodes '11' (read) and '10' (read then post-increment) are reads.
- R6: In a read, `mdio_oe` is low for both turnaround bits and all 16 data bits. The line is sampled on the MDC rising edge of each data bit, MSB first, and the word appears on `rd_data` together with `done`. Non-read frames leave `rd_data` unchanged.
- R7: The master changes its driven bit only on MDC falling edges, so `mdio_o`/`mdio_oe` are constant while MDC is high. Exactly 64 MDC cycles make up one frame.
- R8: `busy` rises the cycle after an accepted start. `done` is a single-cycle pulse, seen 128·(`mdc_half_div`+1)+1 rising clock edges after the start was applied, counting the accepting edge. `busy` is low when `done` is high.
- R9: A `cmd_start` that arrives while `busy` is high is ignored. The running frame continues unchanged and only one `done` occurs.
- R10: Once a frame has completed, `mdio_oe` is low (line released), MDC is low and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_half_div | input | DIV_W | MDC half period minus one, in system cycles |
| cmd_start | input | 1 | One-cycle request to start a frame |
| cmd_ext | input | 1 | 1 = extended indirect frame, 0 = direct register frame |
| cmd_op | input | 2 | Frame opcode |
| cmd_phy | input | 5 | Port (PHY) address |
| cmd_reg | input | 5 | Register or device address |
| cmd_wdata | input | 16 | Write data or address word |
| rd_data | output | 16 | Last captured read word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven when enabled |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The bench builds the block with the default `DIV_W`=8 and sweeps `mdc_half_div` over 0, 1 and 2. The shortest divider setting puts the one-cycle gap between the bench's fall-time data change and the design's rise-time sample within reach. It also exercises all four opcodes of both frame flavours, with port and register addresses at 0, 31 and values in between. Because the frames are short, every bit of every frame can be compared against an arithmetically built 64-bit expectation. A read with a start request injected mid-frame covers the ignore rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN    = 32;
  localparam int ADDR_W     = 5;
  localparam int WORD_W     = 16;
  localparam int CTRL_LEN   = 16;
  localparam int FRAME_LEN  = PRE_LEN + CTRL_LEN + WORD_W;
  localparam int TA_POS     = PRE_LEN + CTRL_LEN - 2;
  localparam int DATA_POS   = PRE_LEN + CTRL_LEN;
  localparam int BIT_W      = $clog2(FRAME_LEN);

  function automatic logic op_is_read(input logic ext, input logic [1:0] op);
    return ext ? op[1] : (op == 2'b10);
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic ext, input logic [1:0] op,
    input logic [ADDR_W-1:0] phy, input logic [ADDR_W-1:0] rg,
    input logic [WORD_W-1:0] wd);
    return {{PRE_LEN{1'b1}}, (ext ? 2'b00 : 2'b01), op, phy, rg, 2'b10, wd};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap = en && (cnt_q == half_div);
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R2: every MDC toggle inside a run comes after a full half period
  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (mdc_q != $past(mdc_q))) |-> ($past(cnt_q) == $past(half_div)));
  // R2: MDC parks low when the generator is disabled
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rg,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              line_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              drv_val,
  output logic              drv_en
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(TA_POS);
  localparam logic [BIT_W-1:0] DAT_BIT  = BIT_W'(DATA_POS);

  logic                 busy_q, busy_d;
  logic                 done_q, done_d;
  logic                 rd_q, rd_d;
  logic [BIT_W-1:0]     bitn_q, bitn_d;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [WORD_W-1:0]    rx_q, rx_d;
  logic [WORD_W-1:0]    rdata_q, rdata_d;
  logic                 accept;

  assign accept = start && !busy_q;

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    rd_d    = rd_q;
    bitn_d  = bitn_q;
    frame_d = frame_q;
    rx_d    = rx_q;
    rdata_d = rdata_q;
    if (accept) begin
      busy_d  = 1'b1;
      rd_d    = op_is_read(ext, op);
      bitn_d  = '0;
      frame_d = build_frame(ext, op, phy, rg, wdata);
      rx_d    = '0;
    end else if (busy_q) begin
      if (rise && rd_q && (bitn_q >= DAT_BIT)) begin
        rx_d = {rx_q[WORD_W-2:0], line_in};
      end
      if (fall) begin
        if (bitn_q == LAST_BIT) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          if (rd_q) rdata_d = rx_q;
        end else begin
          bitn_d  = bitn_q + 1'b1;
          frame_d = {frame_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      bitn_q  <= '0;
      frame_q <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      rd_q    <= rd_d;
      bitn_q  <= bitn_d;
      frame_q <= frame_d;
      rx_q    <= rx_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rdata   = rdata_q;
  assign drv_en  = busy_q && !(rd_q && (bitn_q >= TA_BIT));
  assign drv_val = drv_en && frame_q[FRAME_LEN-1];

  // R8: completion pulse lasts one cycle and coincides with busy low
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R9: a start during a run leaves the frame untouched
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !fall) |=> $stable(frame_q));
  // R7: the driven bit only moves on MDC falling edges
  assert_shift_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(fall)) |-> $stable(bitn_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  mdc_half_div,
  input  logic              cmd_start,
  input  logic              cmd_ext,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic run, mdc_rise, mdc_fall;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run),
    .half_div (mdc_half_div),
    .mdc      (mdc),
    .rise     (mdc_rise),
    .fall     (mdc_fall)
  );

  mdio_frame_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cmd_start),
    .ext     (cmd_ext),
    .op      (cmd_op),
    .phy     (cmd_phy),
    .rg      (cmd_reg),
    .wdata   (cmd_wdata),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .line_in (mdio_i),
    .busy    (run),
    .done    (done),
    .rdata   (rd_data),
    .drv_val (mdio_o),
    .drv_en  (mdio_oe)
  );

  assign busy = run;

  // R10: with no frame running the line is released and MDC is parked
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!mdc && !mdio_oe));
  // R7: drive value and enable hold while MDC is high
  assert_hold_while_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk;
  logic        rst_n;
  logic [7:0]  mdc_half_div;
  logic        cmd_start, cmd_ext;
  logic [1:0]  cmd_op;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] cmd_wdata;
  logic [15:0] rd_data;
  logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int failures = 0;

  // bus model: master drive, else PHY drive, else pull-up
  logic phy_en, phy_val;
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .mdc_half_div(mdc_half_div),
    .cmd_start(cmd_start), .cmd_ext(cmd_ext), .cmd_op(cmd_op),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor state
  bit          mon_active = 0;
  bit          exp_read = 0;
  logic [15:0] rdpat = '0;
  int          cur_d = 0;
  int          idx = 0;
  int          cyc = 0;
  int          last_rise = -1;
  bit          period_err = 0;
  bit          stable_err = 0;
  int          done_cnt = 0;
  logic [63:0] act_o, act_oe;
  logic        prev_mdc = 0, prev_oe = 0, prev_o = 0;

  always @(negedge clk) begin
    if (mon_active) begin
      if (mdc && !prev_mdc) begin
        if (idx < 64) begin
          act_o[63-idx]  = mdio_o;
          act_oe[63-idx] = mdio_oe;
        end
        idx++;
        if (last_rise >= 0 && (cyc - last_rise) != 2*(cur_d+1)) period_err = 1;
        last_rise = cyc;
      end
      if (!mdc && prev_mdc) begin
        if (exp_read && idx >= 47 && idx <= 63) begin
          phy_en  = 1'b1;
          phy_val = (idx == 47) ? 1'b0 : rdpat[63-idx];
        end else begin
          phy_en = 1'b0;
        end
      end
      if (mdc && prev_mdc && (mdio_oe != prev_oe || mdio_o != prev_o)) stable_err = 1;
      if (done) done_cnt++;
    end
    prev_mdc = mdc;
    prev_oe  = mdio_oe;
    prev_o   = mdio_o;
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input int d, input bit ext, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] rp,
                         input bit inject);
    logic [63:0] exp;
    logic [15:0] old_rd;
    bit          rd;
    int          n;
    string       hreq;
    rd   = ext ? op[1] : (op == 2'b10);
    exp  = {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, phy, rg, 2'b10, wd};
    hreq = ext ? "R5" : "R4";
    @(negedge clk);
    old_rd = rd_data;
    cur_d = d; exp_read = rd; rdpat = rp;
    idx = 0; last_rise = -1; period_err = 0; stable_err = 0; done_cnt = 0;
    act_o = '0; act_oe = '0; phy_en = 0;
    mdc_half_div = 8'(d);
    cmd_ext = ext; cmd_op = op; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cmd_start = 1'b1;
    mon_active = 1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      cmd_start = 1'b0;
      if (n == 1) chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
      if (inject && n == 40) begin
        cmd_start = 1'b1;
        cmd_ext = ~ext; cmd_op = ~op; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
      end
    end while (!done && n < 5000);
    chk(n == 128*(d+1)+1, "R8", "done latency", 64'(n), 64'(128*(d+1)+1));
    chk(act_oe[63:32] == 32'hFFFF_FFFF && act_o[63:32] == 32'hFFFF_FFFF,
        "R3", "preamble", act_o[63:32] & act_oe[63:32], 64'hFFFF_FFFF);
    chk(act_oe[31:18] == 14'h3FFF && act_o[31:18] == exp[31:18],
        inject ? "R9" : hreq, "control field", 64'(act_o[31:18]), 64'(exp[31:18]));
    if (rd) begin
      chk(act_oe[17:0] == 18'h0, "R6", "released turnaround/data", 64'(act_oe[17:0]), 64'd0);
      chk(rd_data == rp, inject ? "R9" : "R6", "read word", 64'(rd_data), 64'(rp));
    end else begin
      chk(act_oe[17:0] == 18'h3FFFF && act_o[17:0] == exp[17:0],
          hreq, "turnaround/data drive", 64'(act_o[17:0]), 64'(exp[17:0]));
      chk(rd_data == old_rd, "R6", "rd_data kept on non-read", 64'(rd_data), 64'(old_rd));
    end
    repeat (4*(d+1)+4) @(negedge clk);
    chk(stable_err == 0 && idx == 64, "R7", "bit changes only at fall, 64 cycles",
        64'(idx), 64'd64);
    chk(period_err == 0, "R2", "MDC period", 64'(period_err), 64'd0);
    chk(done_cnt == 1, inject ? "R9" : "R8", "single done", 64'(done_cnt), 64'd1);
    chk(!mdio_oe && !mdc && !busy, "R10", "idle after frame",
        64'({mdio_oe, mdc, busy}), 64'd0);
    mon_active = 0;
    phy_en = 0;
  endtask

  initial begin
    #(4*200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    phy_en = 0; phy_val = 0;
    mdc_half_div = 8'd0;
    cmd_start = 0; cmd_ext = 0; cmd_op = 0; cmd_phy = 0; cmd_reg = 0; cmd_wdata = 0;
    repeat (4) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done && rd_data == 16'h0, "R1", "in reset",
        {44'h0, mdc, mdio_oe, busy, done, rd_data}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done && rd_data == 16'h0, "R1", "after reset",
        {44'h0, mdc, mdio_oe, busy, done, rd_data}, 64'd0);
    for (int d = 0; d < 3; d++)
      for (int e = 0; e < 2; e++)
        for (int o = 0; o < 4; o++)
          run_txn(d, e[0], 2'(o), 5'(o*7 + d*11 + e*3), 5'(o*5 + d*13 + e*9 + 1),
                  16'(16'h1234 * (o+1) + d*16'h0101 + e), 16'(16'hA5C3 ^ (o*16'h1111 + d*16'h0F0F + e)),
                  1'b0);
    run_txn(0, 1'b0, 2'b10, 5'd31, 5'd31, 16'hFFFF, 16'hFFFF, 1'b0);
    run_txn(0, 1'b1, 2'b11, 5'd0, 5'd0, 16'h0000, 16'h0000, 1'b0);
    run_txn(1, 1'b0, 2'b01, 5'd31, 5'd0, 16'h8001, 16'h0000, 1'b0);
    run_txn(1, 1'b0, 2'b10, 5'd9, 5'd22, 16'h0000, 16'h6E2B, 1'b1);
    run_txn(2, 1'b1, 2'b00, 5'd3, 5'd7, 16'hBEEF, 16'h0000, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule